// File: doc/BRIEF.md
# Servo and Duty-Cycle PWM Generator with Pulse Capture

This block drives a bank of PWM outputs and measures a bank of PWM inputs, all behind a small word-wide register port. Each output channel runs in one of two modes, chosen by one bit per channel. Servo mode makes a fixed-period pulse whose high time is clamped to a narrow window. Full-range mode makes a plain duty cycle. In that mode the period comes from a shared register and the high time can be anything from always-low to always-high.

All timing runs on a common tick, made by dividing the system clock (by default 1 µs from 50 MHz). A write to a duty value, the mode or the full-range period never cuts a pulse short. Each generator copies the register values only when its period counter wraps.

Each input passes through a two-stage synchroniser. The reader then measures the high time and the rising-to-rising period, both in ticks. If an input shows no edge for a timeout, a per-channel signal-lost flag is set. Each lost flag can be routed to the interrupt line through a mask.

Top module: `pwm_io_ctrl`

## Requirements
- R1: In servo mode (mode bit 0) the output period is SERVO_PER ticks. The high time is the channel's duty register clamped to the range SERVO_MIN..SERVO_MAX ticks, with the high part at the start of each period.
- R2: In full-range mode (mode bit 1) the period is the shared period register at address 0x09, with 0 treated as 1, and the high time is the duty register. A duty of 0 keeps the output low. A duty at or above the period keeps it high.
- R3: Duty registers sit at addresses 0x00+n. Mode bit n at address 0x08 selects full-range mode for output n.
- R4: A new duty, mode or period value takes effect only at the start of the next period. A pulse already in progress keeps its length.
- R5: For input n, the tick count from a rising edge to the following falling edge is latched and read at address 0x10+n.
- R6: For input n, the tick count between two consecutive rising edges is latched and read at address 0x18+n. The first rising edge after a lost state latches no period.
- R7: If input n shows no edge for TIMEOUT ticks, bit n of the lost register at address 0x0A is set. The next edge clears it.
- R8: irq_o is high exactly when a lost bit is set whose bit in the mask register at address 0x0B is also set.
- R9: After reset all registers read 0, every PWM output is low until the first tick, and irq_o is low.
- R10: A read with req_i high and we_i low returns its data on rdata_o one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, one cycle after the read strobe |
| pwm_o | output | 8 | PWM outputs |
| pwm_i | input | 8 | PWM inputs to be measured |
| irq_o | output | 1 | Masked signal-lost interrupt |

## Verification
The outputs are looped back to the inputs, so each generated pulse is timed twice: once by the bench in clock cycles and once by the reader in ticks. Random mode, duty and period settings cover the cases where servo values fall below, inside and above the clamp window, and where full-range duty is anywhere within the period. These separate errors in the clamp from errors in the duty compare. Directed cases apply duty 0 and a duty above the period, which produce no edges. These show the constant levels, the timeout, the lost flag with its mask, and recovery on the next edge. A write made in the middle of a pulse shows whether the current pulse keeps its length while the following one takes the new value.

// File: rtl/pwm_io_pkg.sv
package pwm_io_pkg;
  localparam int unsigned ADDR_W   = 6;
  localparam logic [5:0] A_MODE    = 6'h08;
  localparam logic [5:0] A_FR_PER  = 6'h09;
  localparam logic [5:0] A_LOST    = 6'h0A;
  localparam logic [5:0] A_MASK    = 6'h0B;
  localparam logic [2:0] G_DUTY    = 3'b000;
  localparam logic [2:0] G_HI      = 3'b010;
  localparam logic [2:0] G_PER     = 3'b011;

  typedef enum logic {MODE_SERVO = 1'b0, MODE_FULL = 1'b1} pwm_mode_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (div_q == DW'(DIV - 1)) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == DW'(DIV - 1));

  generate
    if (DIV > 1) begin : g_chk
      p_tick_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pwm_gen_ch.sv
module pwm_gen_ch
  import pwm_io_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SERVO_PER = 20000,
  parameter int unsigned SERVO_MIN = 1000,
  parameter int unsigned SERVO_MAX = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  pwm_mode_e        mode_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] fr_per_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, per_q, hi_q;
  pwm_mode_e        mode_q;
  logic [CNT_W-1:0] nxt_per, nxt_hi;
  logic             wrap;

  always_comb begin
    if (mode_i == MODE_SERVO) begin
      nxt_per = CNT_W'(SERVO_PER);
      if (duty_i < CNT_W'(SERVO_MIN))      nxt_hi = CNT_W'(SERVO_MIN);
      else if (duty_i > CNT_W'(SERVO_MAX)) nxt_hi = CNT_W'(SERVO_MAX);
      else                                 nxt_hi = duty_i;
    end else begin
      nxt_per = (fr_per_i == '0) ? CNT_W'(1) : fr_per_i;
      nxt_hi  = duty_i;
    end
  end

  assign wrap = tick_i && (cnt_q >= per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= CNT_W'(1);
      hi_q   <= '0;
      mode_q <= MODE_SERVO;
    end else if (wrap) begin
      cnt_q  <= '0;
      per_q  <= nxt_per;
      hi_q   <= nxt_hi;
      mode_q <= mode_i;
    end else if (tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign pwm_o = (cnt_q < hi_q);

  p_servo_max_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SERVO && cnt_q >= CNT_W'(SERVO_MAX)) |-> !pwm_o);
  p_cnt_in_per_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_q);
  p_shadow_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> ($stable(hi_q) && $stable(per_q) && $stable(mode_q)));
endmodule

// File: rtl/pwm_cap_ch.sv
module pwm_cap_ch #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TIMEOUT = 60000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pwm_i,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] per_o,
  output logic             lost_o
);
  logic [2:0]       sync_q;
  logic             rise, fall, edge_seen;
  logic [CNT_W-1:0] cnt_q, idle_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], pwm_i};
  end

  assign rise      = sync_q[1] & ~sync_q[2];
  assign fall      = ~sync_q[1] & sync_q[2];
  assign edge_seen = rise | fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      idle_q  <= '0;
      hi_o    <= '0;
      per_o   <= '0;
      lost_o  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (rise) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) per_o <= cnt_q;
      end else if (tick_i && cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (fall) hi_o <= cnt_q;
      if (edge_seen) begin
        idle_q <= '0;
        lost_o <= 1'b0;
      end else if (tick_i && !lost_o) begin
        idle_q <= idle_q + 1'b1;
        if (idle_q == CNT_W'(TIMEOUT - 1)) begin
          lost_o  <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  p_hi_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(hi_o));
  p_per_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(per_o));
  p_lost_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> !lost_o);
endmodule

// File: rtl/pwm_io_ctrl.sv
module pwm_io_ctrl
  import pwm_io_pkg::*;
#(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TICK_DIV  = 50,
  parameter int unsigned SERVO_PER = 20000,
  parameter int unsigned SERVO_MIN = 1000,
  parameter int unsigned SERVO_MAX = 2000,
  parameter int unsigned TIMEOUT   = 60000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [5:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [N_CH-1:0]   pwm_o,
  input  logic [N_CH-1:0]   pwm_i,
  output logic              irq_o
);
  localparam int unsigned SEL_W = 3;

  logic                 tick;
  logic [CNT_W-1:0]     duty_q [N_CH];
  logic [N_CH-1:0]      mode_q, mask_q, lost;
  logic [CNT_W-1:0]     fr_per_q;
  logic [CNT_W-1:0]     cap_hi [N_CH];
  logic [CNT_W-1:0]     cap_per [N_CH];
  logic                 wr, rd;
  logic [SEL_W-1:0]     sel;
  logic [CNT_W-1:0]     rmux;

  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign sel = addr_i[SEL_W-1:0];

  pwm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      mask_q   <= '0;
      fr_per_q <= '0;
    end else if (wr) begin
      if (addr_i == A_MODE)   mode_q   <= wdata_i[N_CH-1:0];
      if (addr_i == A_MASK)   mask_q   <= wdata_i[N_CH-1:0];
      if (addr_i == A_FR_PER) fr_per_q <= wdata_i;
    end
  end

  generate
    for (genvar n = 0; n < N_CH; n++) begin : g_ch
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) duty_q[n] <= '0;
        else if (wr && addr_i[5:3] == G_DUTY && sel == SEL_W'(n)) duty_q[n] <= wdata_i;
      end

      pwm_gen_ch #(
        .CNT_W(CNT_W), .SERVO_PER(SERVO_PER),
        .SERVO_MIN(SERVO_MIN), .SERVO_MAX(SERVO_MAX)
      ) u_gen (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
        .mode_i(pwm_mode_e'(mode_q[n])), .duty_i(duty_q[n]),
        .fr_per_i(fr_per_q), .pwm_o(pwm_o[n])
      );

      pwm_cap_ch #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_cap (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .pwm_i(pwm_i[n]),
        .hi_o(cap_hi[n]), .per_o(cap_per[n]), .lost_o(lost[n])
      );
    end
  endgenerate

  always_comb begin
    rmux = '0;
    unique case (addr_i[5:3])
      G_DUTY: rmux = duty_q[sel];
      G_HI:   rmux = cap_hi[sel];
      G_PER:  rmux = cap_per[sel];
      3'b001: begin
        case (addr_i)
          A_MODE:   rmux = CNT_W'(mode_q);
          A_FR_PER: rmux = fr_per_q;
          A_LOST:   rmux = CNT_W'(lost);
          A_MASK:   rmux = CNT_W'(mask_q);
          default:  rmux = '0;
        endcase
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rmux;
  end

  assign irq_o = |(lost & mask_q);

  p_irq_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/sim_pwm_io_ctrl.sv
module sim_pwm_io_ctrl;
  localparam int N = 8, D = 4, SP = 100, SMIN = 10, SMAX = 20, TO = 300;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [N-1:0] pwm;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  int duty_m [N];
  bit mode_m [N];
  int frp_m;

  always #2 clk = ~clk;

  pwm_io_ctrl #(.N_CH(N), .CNT_W(16), .TICK_DIV(D), .SERVO_PER(SP),
    .SERVO_MIN(SMIN), .SERVO_MAX(SMAX), .TIMEOUT(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .pwm_i(pwm), .irq_o(irq));

  function automatic int exp_hi(bit m, int d, int fp);
    if (!m) return (d < SMIN) ? SMIN : (d > SMAX) ? SMAX : d;
    return d;
  endfunction
  function automatic int exp_per(bit m, int fp);
    if (!m) return SP;
    return (fp == 0) ? 1 : fp;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, int d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = 16'(d);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [5:0] a, output int d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = int'(rdata);
  endtask

  task automatic wait_cyc(int c);
    repeat (c) @(negedge clk);
  endtask

  // measure one full pulse on channel ch, in clock cycles
  task automatic meas(int ch, output int hi, output int per, output bit ok);
    int guard;
    bit prev;
    ok = 0; hi = 0; per = 0; guard = 0;
    prev = 1;
    while (guard < 2000) begin
      @(negedge clk); guard++;
      if (!prev && pwm[ch]) break;
      prev = pwm[ch];
    end
    if (guard >= 2000) return;
    hi = 1;
    while (pwm[ch] && guard < 4000) begin @(negedge clk); guard++; if (pwm[ch]) hi++; end
    per = hi;
    while (!pwm[ch] && guard < 4000) begin @(negedge clk); guard++; per++; end
    ok = (guard < 4000);
  endtask

  initial begin
    int v, h, p, r;
    bit ok;
    r = $urandom(32'd1234);
    frp_m = 0;
    for (int i = 0; i < N; i++) begin duty_m[i] = 0; mode_m[i] = 0; end
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk(pwm == '0, "R9 pwm after reset", int'(pwm), 0);
    chk(irq == 0, "R9 irq after reset", int'(irq), 0);
    rd(6'h00, v); chk(v == 0, "R9 duty0 reset", v, 0);
    rd(6'h08, v); chk(v == 0, "R9 mode reset", v, 0);
    rd(6'h0B, v); chk(v == 0, "R9 mask reset", v, 0);

    // R10 latency: data appears exactly one cycle after strobe
    wr(6'h09, 16'h0033);
    @(negedge clk); req = 1; we = 0; addr = 6'h09;
    @(negedge clk); req = 0;
    chk(rdata == 16'h0033, "R10 read latency", int'(rdata), 'h33);

    // random mode/duty/period rounds, outputs looped to inputs
    for (int it = 0; it < 6; it++) begin
      frp_m = 5 + int'($urandom_range(55));
      wr(6'h09, frp_m);
      for (int c = 0; c < N; c++) begin
        mode_m[c] = bit'($urandom_range(1));
        duty_m[c] = mode_m[c] ? 1 + int'($urandom_range(frp_m - 2)) : int'($urandom_range(30));
        wr(6'(c), duty_m[c]);
      end
      v = 0;
      for (int c = 0; c < N; c++) v |= int'(mode_m[c]) << c;
      wr(6'h08, v);
      wait_cyc(3 * SP * D);
      for (int c = 0; c < N; c++) begin
        meas(c, h, p, ok);
        chk(ok && h == D * exp_hi(mode_m[c], duty_m[c], frp_m),
            mode_m[c] ? "R2 full high" : "R1 servo high", h, D * exp_hi(mode_m[c], duty_m[c], frp_m));
        chk(p == D * exp_per(mode_m[c], frp_m), "R3 period by mode", p, D * exp_per(mode_m[c], frp_m));
        rd(6'h10 + 6'(c), v);
        chk(v == exp_hi(mode_m[c], duty_m[c], frp_m), "R5 captured high", v, exp_hi(mode_m[c], duty_m[c], frp_m));
        rd(6'h18 + 6'(c), v);
        chk(v == exp_per(mode_m[c], frp_m), "R6 captured period", v, exp_per(mode_m[c], frp_m));
      end
    end

    // R4: write mid-pulse on ch0 (servo, 15 ticks) to 20; current pulse unchanged
    wr(6'h08, 0);
    wr(6'h00, 15);
    wait_cyc(3 * SP * D);
    begin
      bit prev = 1;
      int g = 0;
      while (g < 2000) begin @(negedge clk); g++; if (!prev && pwm[0]) break; prev = pwm[0]; end
      h = 1;
      req = 1; we = 1; addr = 6'h00; wdata = 16'd20;
      @(negedge clk); req = 0; we = 0;
      if (pwm[0]) h++;
      while (pwm[0] && g < 4000) begin @(negedge clk); g++; if (pwm[0]) h++; end
    end
    chk(h == D * 15, "R4 pulse in progress kept", h, D * 15);
    meas(0, h, p, ok);
    chk(ok && h == D * 20, "R4 new value next period", h, D * 20);

    // R2/R7/R8: ch3 duty 0 (always low), ch4 duty above period (always high)
    wr(6'h09, 20);
    wr(6'h03, 0);
    wr(6'h04, 100);
    wr(6'h08, 8'h18);
    wait_cyc(2 * SP * D);
    begin
      bit lo_ok = 1, hi_ok = 1;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (pwm[3]) lo_ok = 0;
        if (!pwm[4]) hi_ok = 0;
      end
      chk(lo_ok, "R2 duty 0 constant low", int'(pwm[3]), 0);
      chk(hi_ok, "R2 duty over period constant high", int'(pwm[4]), 1);
    end
    rd(6'h0A, v);
    chk(v == 0, "R7 not lost before timeout", v, 0);
    wait_cyc(TO * D);
    rd(6'h0A, v);
    chk(v == 'h18, "R7 lost flags set", v, 'h18);
    chk(irq == 0, "R8 irq masked", int'(irq), 0);
    wr(6'h0B, 8'h08);
    chk(irq == 1, "R8 irq unmasked", int'(irq), 1);
    wr(6'h0B, 8'h01);
    chk(irq == 0, "R8 irq other mask bit", int'(irq), 0);
    wr(6'h0B, 8'h08);
    wr(6'h03, 5);
    wait_cyc(3 * 20 * D);
    rd(6'h0A, v);
    chk(v == 'h10, "R7 lost cleared by edge", v, 'h10);
    chk(irq == 0, "R8 irq drops after recovery", int'(irq), 0);
    meas(3, h, p, ok);
    chk(ok && h == D * 5 && p == D * 20, "R2 recovered full-range", h, D * 5);
    rd(6'h13, v);
    chk(v == 5, "R5 capture after recovery", v, 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule